// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a set of small memory-mapped control registers for a peripheral bus. It holds three byte-wide registers (configuration, diagnostic, modem control), two auxiliary registers with side effects on write, a 16-bit diagnostic LED register and a system-control register. The bus decoder drives one select line per register and a word offset. Write data is taken on a clock edge. Read data is returned combinationally and zero-extended to 32 bits.

The block raises a level interrupt when an external power-fail condition has been latched and the interrupt is enabled. It gives a one-cycle terminal-count pulse to a floppy controller. It gives one-cycle power-off and system-reset request pulses to the power and reset logic.

A soft reset input clears the volatile control state and keeps the diagnostic, LED and reset-status state. The asynchronous power-on reset clears everything.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `irq_o` is high exactly when the power-fail status bit (aux2 bit 5) and the power-interrupt enable (configuration bit 3) are both 1.
- R2: `pwr_fail_i` passes through a two-flop synchroniser. Each time the synchronised level changes, the status bit is loaded with (new level AND enable). A change of the input therefore shows in the status two clock edges later, and a power fail seen while the enable is 0 leaves the status at 0.
- R3: An aux2 write stores only data bit 0 (power off). Software can never set the status bit, and a write with bit 1 clear leaves the status bit unchanged.
- R4: An aux2 write with data bit 1 (interrupt clear) set clears the status bit. Bit 1 always reads 0, and bit 0 takes the written value.
- R5: An aux2 write with data bit 0 set drives `pwroff_req_o` high for the single cycle after the write edge.
- R6: An aux1 write with data bit 1 set drives `tc_o` high for the single cycle after the write edge. Bit 1 is never stored and reads 0. The other seven bits are stored.
- R7: A system-control write at offset 0 with data bit 0 set makes the register read 0x02 and pulses `sysrst_req_o` for one cycle. Writes with bit 0 clear, and writes at other offsets, have no effect. Reads at other offsets return 0.
- R8: The LED register stores data bits 15:0 at offset 0 only. Reads at other offsets return 0, and writes at other offsets are ignored.
- R9: The configuration, diagnostic and modem registers store data bits 7:0 and read back zero-extended. The select bits are: 0 configuration, 1 diagnostic, 2 modem, 3 LED, 4 system control, 5 aux1, 6 aux2. With no select active, read data is 0.
- R10: A `soft_rst_i` cycle clears configuration, modem, aux1 and aux2 (including the status bit). It keeps the diagnostic, LED and system-control contents.
- R11: After power-on reset every register reads 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| soft_rst_i | input | 1 | Synchronous soft reset, one cycle |
| sel_i | input | 7 | One-hot register select from the bus decoder |
| addr_i | input | 2 | Word offset within the selected register window |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero-extended |
| pwr_fail_i | input | 1 | Asynchronous power-failing indication |
| irq_o | output | 1 | Power-fail interrupt level |
| tc_o | output | 1 | Floppy terminal-count pulse |
| pwroff_req_o | output | 1 | Power-off request pulse |
| sysrst_req_o | output | 1 | System reset request pulse |

## Verification
A wrong status bit shows up in two places: on `irq_o` during the same cycle it changes, and on aux2 bit 5 at the next read. Because of this, the enable/clear/status interplay is checked on both outputs after each step. Pulse outputs are sampled in the cycle right after the write edge and again one cycle later, so a pulse that is stuck high or shifted by a cycle is caught. Soft-reset and offset-ignoring faults only become visible when the untouched register is read back. For that reason every such stimulus is followed by a readback of the register it must not have changed.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;
  localparam int DATA_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int LED_W   = 16;
  localparam int NUM_SEL = 7;

  // select positions from the bus decoder
  localparam int SEL_CFG  = 0;
  localparam int SEL_DIAG = 1;
  localparam int SEL_MDM  = 2;
  localparam int SEL_LED  = 3;
  localparam int SEL_SYS  = 4;
  localparam int SEL_AUX1 = 5;
  localparam int SEL_AUX2 = 6;
  localparam int NUM_BYTE_REGS = 3;  // cfg, diag, mdm occupy selects 0..2

  localparam int CFG_PF_EN_BIT = 3;
  localparam int AUX1_TC_BIT   = 1;
  localparam int AUX2_OFF_BIT  = 0;
  localparam int AUX2_CLR_BIT  = 1;
  localparam int AUX2_PF_BIT   = 5;
  localparam int SYS_RST_BIT   = 0;
  localparam int SYS_STAT_BIT  = 1;
endpackage

// File: rtl/aux_pf_sync.sv
module aux_pf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o,
  output logic chg_o    // synchronised level about to change on next edge
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], async_i};
  end

  assign sync_o = q[STAGES-1];
  assign chg_o  = q[STAGES-1] ^ q[STAGES-2];
endmodule

// File: rtl/aux_pwr_ctrl.sv
module aux_pwr_ctrl
  import aux_sysctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_clr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              pf_next_i,
  input  logic              pf_chg_i,
  input  logic              en_i,
  output logic              off_q_o,
  output logic              pf_st_o,
  output logic              off_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q_o   <= 1'b0;
      pf_st_o   <= 1'b0;
      off_req_o <= 1'b0;
    end else begin
      off_req_o <= wr_i & wdata_i[AUX2_OFF_BIT];
      if (soft_clr_i) begin
        off_q_o <= 1'b0;
        pf_st_o <= 1'b0;
      end else begin
        if (wr_i) begin
          off_q_o <= wdata_i[AUX2_OFF_BIT];
          if (wdata_i[AUX2_CLR_BIT]) pf_st_o <= 1'b0;
        end
        // a level change of the synchronised input overrides a same-cycle clear
        if (pf_chg_i) pf_st_o <= pf_next_i & en_i;
      end
    end
  end

  AST_PF_NO_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pf_st_o) |-> $past(pf_chg_i && pf_next_i && en_i)); // R3
  AST_PF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[AUX2_CLR_BIT] && !pf_chg_i) |=> !pf_st_o); // R4
  AST_OFF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_req_o |-> $past(wr_i && wdata_i[AUX2_OFF_BIT])); // R5
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_sysctl_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int PF_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic [NUM_SEL-1:0] sel_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               pwr_fail_i,
  output logic               irq_o,
  output logic               tc_o,
  output logic               pwroff_req_o,
  output logic               sysrst_req_o
);
  localparam logic [BYTE_W-1:0] AUX1_MASK = ~(BYTE_W'(1) << AUX1_TC_BIT);

  logic [NUM_SEL-1:0] we;
  logic [DATA_W-1:0]  rd_vec [NUM_SEL];
  logic [BYTE_W-1:0]  byte_q [NUM_BYTE_REGS];
  logic [BYTE_W-1:0]  aux1_q;
  logic [LED_W-1:0]   led_q;
  logic               sys_st_q;
  logic               off_q, pf_st, pf_sync, pf_chg;
  logic               at_zero;
  logic               unused_wdata;

  assign we      = sel_i & {NUM_SEL{wr_i}};
  assign at_zero = (addr_i == '0);
  assign unused_wdata = ^wdata_i[DATA_W-1:LED_W];

  // plain byte registers; diagnostic survives soft reset
  for (genvar g = 0; g < NUM_BYTE_REGS; g++) begin : g_byte
    localparam bit SOFT_CLR = (g != SEL_DIAG);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     byte_q[g] <= '0;
      else if (SOFT_CLR && soft_rst_i) byte_q[g] <= '0;
      else if (we[g])                  byte_q[g] <= wdata_i[BYTE_W-1:0];
    end
    assign rd_vec[g] = DATA_W'(byte_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aux1_q <= '0;
      tc_o   <= 1'b0;
    end else begin
      tc_o <= we[SEL_AUX1] & wdata_i[AUX1_TC_BIT];
      if (soft_rst_i)          aux1_q <= '0;
      else if (we[SEL_AUX1])   aux1_q <= wdata_i[BYTE_W-1:0] & AUX1_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    led_q <= '0;
    else if (we[SEL_LED] && at_zero) led_q <= wdata_i[LED_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_st_q     <= 1'b0;
      sysrst_req_o <= 1'b0;
    end else begin
      sysrst_req_o <= we[SEL_SYS] & at_zero & wdata_i[SYS_RST_BIT];
      if (we[SEL_SYS] && at_zero && wdata_i[SYS_RST_BIT]) sys_st_q <= 1'b1;
    end
  end

  aux_pf_sync #(.STAGES(PF_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pwr_fail_i),
    .sync_o  (pf_sync),
    .chg_o   (pf_chg)
  );

  logic pf_next;
  assign pf_next = ~pf_sync;  // value the synchronised level takes on a change

  aux_pwr_ctrl u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_clr_i (soft_rst_i),
    .wr_i       (we[SEL_AUX2]),
    .wdata_i    (wdata_i[BYTE_W-1:0]),
    .pf_next_i  (pf_next),
    .pf_chg_i   (pf_chg),
    .en_i       (byte_q[SEL_CFG][CFG_PF_EN_BIT]),
    .off_q_o    (off_q),
    .pf_st_o    (pf_st),
    .off_req_o  (pwroff_req_o)
  );

  assign irq_o = pf_st & byte_q[SEL_CFG][CFG_PF_EN_BIT];

  always_comb begin
    rd_vec[SEL_LED]  = at_zero ? DATA_W'(led_q) : '0;
    rd_vec[SEL_SYS]  = at_zero ? (DATA_W'(sys_st_q) << SYS_STAT_BIT) : '0;
    rd_vec[SEL_AUX1] = DATA_W'(aux1_q);
    rd_vec[SEL_AUX2] = (DATA_W'(pf_st) << AUX2_PF_BIT) | (DATA_W'(off_q) << AUX2_OFF_BIT);
    rdata_o = '0;
    for (int i = 0; i < NUM_SEL; i++)
      if (sel_i[i]) rdata_o = rdata_o | rd_vec[i];
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i)); // R9
  AST_TC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> $past(wr_i && sel_i[SEL_AUX1] && wdata_i[AUX1_TC_BIT])); // R6
  AST_SYSRST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysrst_req_o |-> $past(wr_i && sel_i[SEL_SYS] && addr_i == '0 && wdata_i[SYS_RST_BIT])); // R7
  AST_SOFT_KEEP_DIAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !we[SEL_DIAG]) |=> $stable(byte_q[SEL_DIAG])); // R10
  AST_SOFT_CLR_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (byte_q[SEL_CFG] == '0 && !irq_o)); // R10
  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rdata_o[AUX2_PF_BIT] || !sel_i[SEL_AUX2])); // R1
endmodule

// File: tb/aux_sysctl_regs_test.sv
module aux_sysctl_regs_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic [6:0]  sel_i = '0;
  logic [1:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        pwr_fail_i = 1'b0;
  logic        irq_o, tc_o, pwroff_req_o, sysrst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  aux_sysctl_regs uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .sel_i(sel_i), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .pwr_fail_i(pwr_fail_i), .irq_o(irq_o),
    .tc_o(tc_o), .pwroff_req_o(pwroff_req_o), .sysrst_req_o(sysrst_req_o)
  );

  localparam logic [6:0] S_CFG = 7'h01, S_DIAG = 7'h02, S_MDM = 7'h04, S_LED = 7'h08,
                         S_SYS = 7'h10, S_AUX1 = 7'h20, S_AUX2 = 7'h40;

  typedef struct packed {
    logic [6:0]  sel;
    logic [1:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{S_CFG,  2'd0, 32'hFFFF_FFA5, 32'h0000_00A5},  // R9
    '{S_DIAG, 2'd0, 32'h1234_5678, 32'h0000_0078},  // R9
    '{S_MDM,  2'd0, 32'h0000_003C, 32'h0000_003C},  // R9
    '{S_LED,  2'd0, 32'hDEAD_BEEF, 32'h0000_BEEF},  // R8
    '{S_LED,  2'd1, 32'h0000_1111, 32'h0000_0000},  // R8
    '{S_AUX1, 2'd0, 32'h0000_00FF, 32'h0000_00FD},  // R6
    '{S_AUX2, 2'd0, 32'h0000_00FF, 32'h0000_0001},  // R4
    '{S_AUX2, 2'd0, 32'h0000_0020, 32'h0000_0000},  // R3
    '{S_SYS,  2'd2, 32'h0000_0001, 32'h0000_0000},  // R7
    '{S_SYS,  2'd0, 32'h0000_0000, 32'h0000_0000}   // R7
  };
  localparam string VTAG [NV] = '{"R9","R9","R9","R8","R8","R6","R4","R3","R7","R7"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] s, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    sel_i = s; addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; sel_i = '0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic rd(input logic [6:0] s, input logic [1:0] a, output logic [31:0] d);
    sel_i = s; addr_i = a;
    #1 d = rdata_o;
    sel_i = '0; addr_i = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R11 reset state
    for (int i = 0; i < 7; i++) begin
      rd(7'(1) << i, 2'd0, d);
      chk("R11 reg zero", d, 32'h0);
    end
    chk("R11 outputs low", {28'h0, irq_o, tc_o, pwroff_req_o, sysrst_req_o}, 32'h0);
    rd(7'h00, 2'd0, d);
    chk("R9 no select", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].sel, VECS[i].addr, VECS[i].wd);
      rd(VECS[i].sel, VECS[i].addr, d);
      chk(VTAG[i], d, VECS[i].exp);
    end
    rd(S_LED, 2'd0, d);
    chk("R8 offset write ignored", d, 32'h0000_BEEF);

    // R6 terminal count pulse
    @(negedge clk_i); sel_i = S_AUX1; wdata_i = 32'h02; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0; sel_i = '0; wdata_i = '0;
    chk("R6 tc high", {31'h0, tc_o}, 32'h1);
    @(negedge clk_i);
    chk("R6 tc one cycle", {31'h0, tc_o}, 32'h0);
    rd(S_AUX1, 2'd0, d);
    chk("R6 tc bit not stored", d, 32'h0);

    // R5 power-off pulse
    @(negedge clk_i); sel_i = S_AUX2; wdata_i = 32'h01; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0; sel_i = '0; wdata_i = '0;
    chk("R5 pwroff high", {31'h0, pwroff_req_o}, 32'h1);
    @(negedge clk_i);
    chk("R5 pwroff one cycle", {31'h0, pwroff_req_o}, 32'h0);

    // R7 system reset
    @(negedge clk_i); sel_i = S_SYS; wdata_i = 32'h01; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0; sel_i = '0; wdata_i = '0;
    chk("R7 sysrst high", {31'h0, sysrst_req_o}, 32'h1);
    @(negedge clk_i);
    chk("R7 sysrst one cycle", {31'h0, sysrst_req_o}, 32'h0);
    rd(S_SYS, 2'd0, d);
    chk("R7 reset status", d, 32'h2);
    rd(S_SYS, 2'd1, d);
    chk("R7 other offset reads 0", d, 32'h0);

    // R1 R2 power fail path
    wr(S_AUX2, 2'd0, 32'h0);
    wr(S_CFG, 2'd0, 32'h08);
    pwr_fail_i = 1'b1;
    @(negedge clk_i);
    chk("R2 not yet after one edge", {31'h0, irq_o}, 32'h0);
    @(negedge clk_i);
    chk("R2 irq after two edges", {31'h0, irq_o}, 32'h1);
    rd(S_AUX2, 2'd0, d);
    chk("R2 status set", d, 32'h20);
    wr(S_CFG, 2'd0, 32'h00);
    chk("R1 irq off when disabled", {31'h0, irq_o}, 32'h0);
    rd(S_AUX2, 2'd0, d);
    chk("R1 status kept", d, 32'h20);
    wr(S_CFG, 2'd0, 32'h08);
    chk("R1 irq back on", {31'h0, irq_o}, 32'h1);
    wr(S_AUX2, 2'd0, 32'h00);
    rd(S_AUX2, 2'd0, d);
    chk("R3 write keeps status", d, 32'h20);
    wr(S_AUX2, 2'd0, 32'h03);
    rd(S_AUX2, 2'd0, d);
    chk("R4 clear keeps off bit", d, 32'h01);
    chk("R4 irq cleared", {31'h0, irq_o}, 32'h0);
    pwr_fail_i = 1'b0;
    idle(3);
    wr(S_CFG, 2'd0, 32'h00);
    pwr_fail_i = 1'b1;
    idle(3);
    rd(S_AUX2, 2'd0, d);
    chk("R2 disabled fail ignored", d, 32'h01);
    pwr_fail_i = 1'b0;
    idle(3);

    // R10 soft reset
    wr(S_CFG, 2'd0, 32'h08);
    wr(S_MDM, 2'd0, 32'h5A);
    wr(S_AUX1, 2'd0, 32'h81);
    wr(S_DIAG, 2'd0, 32'h66);
    @(negedge clk_i); soft_rst_i = 1'b1;
    @(negedge clk_i); soft_rst_i = 1'b0;
    rd(S_CFG, 2'd0, d);  chk("R10 cfg cleared", d, 32'h0);
    rd(S_MDM, 2'd0, d);  chk("R10 mdm cleared", d, 32'h0);
    rd(S_AUX1, 2'd0, d); chk("R10 aux1 cleared", d, 32'h0);
    rd(S_AUX2, 2'd0, d); chk("R10 aux2 cleared", d, 32'h0);
    rd(S_DIAG, 2'd0, d); chk("R10 diag kept", d, 32'h66);
    rd(S_SYS, 2'd0, d);  chk("R10 sys kept", d, 32'h2);
    rd(S_LED, 2'd0, d);  chk("R10 led kept", d, 32'hBEEF);

    // R11 power-on reset clears everything
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rd(S_DIAG, 2'd0, d); chk("R11 diag zero", d, 32'h0);
    rd(S_SYS, 2'd0, d);  chk("R11 sys zero", d, 32'h0);
    rd(S_LED, 2'd0, d);  chk("R11 led zero", d, 32'h0);

    idle(2);
    finish_run();
  end
endmodule